// File: doc/BRIEF.md
# PHY Test-Port Register Bridge

This block is the single 32-bit configuration word of a multi-protocol serial PHY. Two of its bits drive plain controls: one bypasses the line encoder and decoder, and one enables the reference clock output toward the link partner. The other fields form a small test port. Through it, software writes a 32-entry by 4-bit internal register array inside the PHY.

To perform an internal write, software first stores an address and a data value in the word with the strobe bit clear. It then writes the word again with the strobe bit set. The array entry is committed only on the clock edge where the strobe goes from 0 to 1. The address and data used are the ones carried by that same bus write. The whole array is brought out on a flat vector so that neighbouring logic and checkers can observe it.

The bus side has no back-pressure. A write (`cfg_we` high for one cycle) is always accepted on the next rising clock edge. The read data is the stored word, visible continuously. Neither side of the bus has a valid/ready pair, because every access completes in one cycle.

Top module: `phy_tp_bridge`

## Requirements
- R1: While `rst_n` is low and after it is released, the config word reads 0, `codec_bypass` and `refclk_oe` are 0, and every array entry is 0.
- R2: After a cycle with `cfg_we` high, `cfg_rdata` equals the written word from the following clock edge onward.
- R3: `codec_bypass` equals bit 31 of the stored word, where 1 bypasses the codec and 0 leaves encoding and decoding enabled.
- R4: `refclk_oe` equals bit 0 of the stored word.
- R5: If a write sets bit 24 (the strobe) while the stored word has bit 24 clear, the entry selected by the written bits 16:12 takes the written bits 23:20 on that same edge. Entry k occupies `tp_array[4k+3:4k]`.
- R6: A write with bit 24 set while the stored bit 24 is already 1 changes no array entry, even if the address or data fields change.
- R7: A write with bit 24 clear changes no array entry, but it does update the stored address and data fields.
- R8: Cycles without `cfg_we` change neither the stored word nor the array.
- R9: All 32 entries, including addresses 0 and 31, are written independently, and a write to one entry leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write enable for the config word |
| cfg_wdata | input | 32 | Word to write |
| cfg_rdata | output | 32 | Stored config word |
| codec_bypass | output | 1 | 1 bypasses the encoder/decoder |
| refclk_oe | output | 1 | Reference clock output enable |
| tp_array | output | 128 | Internal test array, entry k at bits 4k+3:4k |

## Verification
The hardest case to reach is a write that sets the strobe while it is already set, with new address and data fields. A correct design must ignore it, but it looks exactly like a valid trigger. The stimulus reaches this case by leaving the strobe at 1 after a real commit and then rewriting the word with a fresh address and data. A re-arm with the strobe clear comes next, and it must still not commit. The bench then sweeps all 32 addresses with arm/fire pairs to show that the entries are independent.

// File: rtl/phy_tp_pkg.sv
package phy_tp_pkg;
  localparam int CFG_W      = 32;
  localparam int BYPASS_BIT = 31;
  localparam int STROBE_BIT = 24;
  localparam int DATA_LSB   = 20;
  localparam int DATA_W     = 4;
  localparam int ADDR_LSB   = 12;
  localparam int ADDR_W     = 5;
  localparam int REFCLK_BIT = 0;
endpackage

// File: rtl/phy_tp_cfg_reg.sv
module phy_tp_cfg_reg #(
  parameter int CFG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wdata;
  end
endmodule

// File: rtl/phy_tp_strobe_det.sv
module phy_tp_strobe_det #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 4
) (
  input  logic              we,
  input  logic              new_strobe,
  input  logic              cur_strobe,
  input  logic [ADDR_W-1:0] new_addr,
  input  logic [DATA_W-1:0] new_data,
  output logic              fire,
  output logic [ADDR_W-1:0] fire_addr,
  output logic [DATA_W-1:0] fire_data
);
  // rising edge measured against the stored word, not a delayed copy
  always_comb begin
    fire      = we && new_strobe && !cur_strobe;
    fire_addr = new_addr;
    fire_data = new_data;
  end
endmodule

// File: rtl/phy_tp_array.sv
module phy_tp_array #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [DATA_W-1:0]       wdata,
  output logic [DEPTH*DATA_W-1:0] flat
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic [DATA_W-1:0] ent;
    always_ff @(posedge clk) begin
      if (!rst_n) ent <= '0;
      else if (wr && (waddr == ADDR_W'(i))) ent <= wdata;
    end
    assign flat[i*DATA_W +: DATA_W] = ent;
  end
endmodule

// File: rtl/phy_tp_bridge.sv
module phy_tp_bridge #(
  parameter int CFG_W      = phy_tp_pkg::CFG_W,
  parameter int ADDR_W     = phy_tp_pkg::ADDR_W,
  parameter int DATA_W     = phy_tp_pkg::DATA_W,
  parameter int ADDR_LSB   = phy_tp_pkg::ADDR_LSB,
  parameter int DATA_LSB   = phy_tp_pkg::DATA_LSB,
  parameter int STROBE_BIT = phy_tp_pkg::STROBE_BIT,
  parameter int BYPASS_BIT = phy_tp_pkg::BYPASS_BIT,
  parameter int REFCLK_BIT = phy_tp_pkg::REFCLK_BIT,
  localparam int ARR_W     = (1 << ADDR_W) * DATA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  output logic             codec_bypass,
  output logic             refclk_oe,
  output logic [ARR_W-1:0] tp_array
);
  logic [CFG_W-1:0]  word_q;
  logic              fire;
  logic [ADDR_W-1:0] fire_addr;
  logic [DATA_W-1:0] fire_data;

  phy_tp_cfg_reg #(.CFG_W(CFG_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .q(word_q)
  );

  phy_tp_strobe_det #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_det (
    .we(cfg_we),
    .new_strobe(cfg_wdata[STROBE_BIT]),
    .cur_strobe(word_q[STROBE_BIT]),
    .new_addr(cfg_wdata[ADDR_LSB +: ADDR_W]),
    .new_data(cfg_wdata[DATA_LSB +: DATA_W]),
    .fire(fire), .fire_addr(fire_addr), .fire_data(fire_data)
  );

  phy_tp_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .wr(fire), .waddr(fire_addr),
    .wdata(fire_data), .flat(tp_array)
  );

  assign cfg_rdata    = word_q;
  assign codec_bypass = word_q[BYPASS_BIT];
  assign refclk_oe    = word_q[REFCLK_BIT];
endmodule

// File: rtl/phy_tp_bridge_chk.sv
module phy_tp_bridge_chk #(
  parameter int CFG_W      = 32,
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 4,
  parameter int ADDR_LSB   = 12,
  parameter int DATA_LSB   = 20,
  parameter int STROBE_BIT = 24,
  parameter int BYPASS_BIT = 31,
  parameter int REFCLK_BIT = 0,
  localparam int ARR_W     = (1 << ADDR_W) * DATA_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [CFG_W-1:0] cfg_wdata,
  input logic [CFG_W-1:0] cfg_rdata,
  input logic             codec_bypass,
  input logic             refclk_oe,
  input logic [ARR_W-1:0] tp_array
);
  logic trig;
  assign trig = cfg_we && cfg_wdata[STROBE_BIT] && !cfg_rdata[STROBE_BIT];

  // R2
  word_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata == $past(cfg_wdata));

  // R8
  word_holds_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_rdata));

  // R3
  bypass_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    codec_bypass == cfg_rdata[BYPASS_BIT]);

  // R4
  refclk_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refclk_oe == cfg_rdata[REFCLK_BIT]);

  // R5
  commit_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> tp_array[$past(cfg_wdata[ADDR_LSB +: ADDR_W]) * DATA_W +: DATA_W]
             == $past(cfg_wdata[DATA_LSB +: DATA_W]));

  // R6 R7
  no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trig |=> $stable(tp_array));
endmodule

bind phy_tp_bridge phy_tp_bridge_chk #(
  .CFG_W(CFG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ADDR_LSB(ADDR_LSB),
  .DATA_LSB(DATA_LSB), .STROBE_BIT(STROBE_BIT), .BYPASS_BIT(BYPASS_BIT),
  .REFCLK_BIT(REFCLK_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .codec_bypass(codec_bypass), .refclk_oe(refclk_oe),
  .tp_array(tp_array)
);

// File: tb/sim_phy_tp_bridge.sv
module sim_phy_tp_bridge;
  logic         clk = 0;
  logic         rst_n = 0;
  logic         cfg_we = 0;
  logic [31:0]  cfg_wdata = '0;
  logic [31:0]  cfg_rdata;
  logic         codec_bypass, refclk_oe;
  logic [127:0] tp_array;

  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct {
    logic [31:0]  word;
    logic [127:0] arr;
  } exp_t;
  exp_t  expq[$];
  string tagq[$];

  logic [31:0]  m_word = '0;
  logic [127:0] m_arr  = '0;

  always #2.5 clk = ~clk;

  phy_tp_bridge u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .codec_bypass(codec_bypass),
    .refclk_oe(refclk_oe), .tp_array(tp_array)
  );

  task automatic chk32(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic push(string tag);
    exp_t e;
    e.word = m_word;
    e.arr  = m_arr;
    expq.push_back(e);
    tagq.push_back(tag);
  endtask

  task automatic wr(logic [31:0] w, string tag);
    @(negedge clk);
    cfg_we = 1;
    cfg_wdata = w;
    @(posedge clk);
    #1;
    cfg_we = 0;
    if (w[24] && !m_word[24]) m_arr[w[16:12]*4 +: 4] = w[23:20];
    m_word = w;
    push(tag);
  endtask

  task automatic idle(string tag);
    @(negedge clk);
    cfg_wdata = 32'hFFFF_FFFF;
    @(posedge clk);
    #1;
    push(tag);
  endtask

  function automatic logic [31:0] mk(logic [4:0] a, logic [3:0] d, logic s);
    return {7'd0, s, d, 3'd0, a, 12'd0};
  endfunction

  // monitor
  always @(negedge clk) begin
    while (expq.size() > 0) begin
      exp_t  e;
      string t;
      e = expq.pop_front();
      t = tagq.pop_front();
      chk32({t, " word"},   {96'd0, cfg_rdata}, {96'd0, e.word});
      chk32({t, " array"},  tp_array, e.arr);
      chk32("R3 bypass",    {127'd0, codec_bypass}, {127'd0, e.word[31]});
      chk32("R4 refclk",    {127'd0, refclk_oe},    {127'd0, e.word[0]});
    end
  end

  initial begin : wdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk32("R1 reset word",   {96'd0, cfg_rdata}, 128'd0);
    chk32("R1 reset array",  tp_array, 128'd0);
    chk32("R1 reset bypass", {127'd0, codec_bypass}, 128'd0);
    chk32("R1 reset refclk", {127'd0, refclk_oe}, 128'd0);
    rst_n = 1;
    @(negedge clk);
    chk32("R1 after release", {96'd0, cfg_rdata}, 128'd0);

    wr(mk(5'd1, 4'h8, 1'b0), "R7 arm");
    wr(mk(5'd1, 4'h8, 1'b1), "R5 fire");
    wr(mk(5'd12, 4'h9, 1'b1), "R6 strobe held");
    idle("R8 idle a");
    idle("R8 idle b");
    wr(mk(5'd12, 4'h9, 1'b0), "R7 rearm");
    wr(mk(5'd12, 4'h9, 1'b1), "R5 fire b");
    wr(mk(5'd31, 4'hF, 1'b0) | 32'h8000_0001, "R3 R4 arm");
    wr(mk(5'd31, 4'hF, 1'b1) | 32'h8000_0001, "R9 top entry");
    wr(mk(5'd0, 4'h5, 1'b0), "R7 arm zero");
    wr(mk(5'd0, 4'h5, 1'b1), "R9 bottom entry");
    wr(mk(5'd0, 4'h6, 1'b1), "R6 rewrite one");
    for (int i = 0; i < 32; i++) begin
      wr(mk(5'(i), 4'(i + 3), 1'b0), "R7 sweep arm");
      wr(mk(5'(i), 4'(i + 3), 1'b1), "R9 sweep fire");
    end
    idle("R8 idle end");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule